// File: doc/BRIEF.md
# Privilege-Aware Address Segment Decoder

This block classifies each 32-bit virtual address that a load/store pipeline issues. It works out the effective privilege from the status bits and decides where the access goes. The access is sent to the translation lookaside buffer (TLB), mapped straight onto a physical address, or rejected with an address-error code. For the directly mapped windows it also produces the physical address and a cached/uncached flag. It passes on the address sign-extended to 64 bits, so that a downstream TLB stage or exception handler compares full-width values.

Requests enter through a valid/ready handshake, and results leave through another one. A request is taken on a rising clock edge when `req_valid` and `req_ready` are both high. Its result is presented one cycle later. `req_ready` is high whenever the result slot is empty or is being drained in the same cycle (`!rsp_valid || rsp_ready`). A result stays on the outputs, unchanged, until the consumer takes it with `rsp_ready`. Back-to-back requests therefore flow at one per cycle while the consumer keeps up, and stall cleanly when it does not.

Top module: `addr_seg_decoder`

## Requirements
- R1: The effective mode is kernel when `req_mode` is 2'b00 or when `req_exl` or `req_erl` is 1. With both exception flags at 0, mode 2'b01 (supervisor), 2'b10 (user) and 2'b11 (reserved) are all non-kernel and behave identically for every window.
- R2: With `req_erl` at 0, any address with bit 31 clear is routed to the TLB in every mode, with `rsp_exc` = 0, `rsp_cached` = 0 and `rsp_pa` = 0.
- R3: In kernel mode, an address with bits [31:29] = 3'b100 is routed direct and cached, and `rsp_pa` equals bits [28:0] of the address zero-extended to 32 bits.
- R4: In kernel mode, an address with bits [31:29] = 3'b101 is routed direct and uncached, and `rsp_pa` equals bits [28:0] of the address zero-extended.
- R5: In kernel mode, an address with bits [31:30] = 2'b11 is routed to the TLB, uncached, with `rsp_pa` = 0.
- R6: In non-kernel mode, an address with bit 31 set is routed to error. `rsp_exc` is 5 for a store (`req_write` = 1) and 4 for a load. For every non-error route `rsp_exc` is 0.
- R7: With `req_erl` at 1, an address with bit 31 clear is routed direct and uncached, and `rsp_pa` equals bits [30:0] of the address zero-extended.
- R8: `rsp_va` is the request address sign-extended from bit 31 to 64 bits.
- R9: A result appears on the outputs on the clock edge after its request is accepted. `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` and every result field hold their values.
- R10: During and right after reset `rsp_valid` is 0 and `req_ready` is 1.
- R11: `rsp_route` is one-hot with bit 0 = TLB, bit 1 = direct, bit 2 = error. `rsp_cached` is 1 only for the route of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_va | input | 32 | Virtual address |
| req_mode | input | 2 | Privilege mode field |
| req_exl | input | 1 | Exception-level status flag |
| req_erl | input | 1 | Error-level status flag |
| req_write | input | 1 | 1 for store, 0 for load |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result this cycle |
| rsp_route | output | 3 | One-hot route: [0] TLB, [1] direct, [2] error |
| rsp_cached | output | 1 | Direct access is cacheable |
| rsp_pa | output | 32 | Physical address for direct routes, else 0 |
| rsp_exc | output | 5 | Exception code: 4 load error, 5 store error, 0 none |
| rsp_va | output | 64 | Sign-extended virtual address |

## Verification
The hardest situation to reach is a result that sits stalled under back-pressure while new requests keep arriving with different status bits. A wrong handshake would then let a later classification overwrite the held one. The stimulus toggles the consumer's ready from a pseudo-random sequence while the driver issues requests every cycle. It sweeps the privilege field and both exception flags against addresses whose top three bits are chosen evenly. This keeps the stalled result's status combination, such as the error-level low window, different from its successor's.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int VA_W  = 32;
  localparam int EXT_W = 64;
  localparam int PA_W  = 32;
  localparam int EXC_W = 5;
  localparam int KWIN_BITS = 29;   // offset bits inside a kernel direct window
  localparam int LOWWIN_BITS = 31; // offset bits of the low 2 GB region

  typedef enum logic [2:0] {
    RT_TLB    = 3'b001,
    RT_DIRECT = 3'b010,
    RT_ERR    = 3'b100
  } route_t;

  localparam logic [EXC_W-1:0] EXC_NONE       = 5'd0;
  localparam logic [EXC_W-1:0] EXC_ADDR_LOAD  = 5'd4;
  localparam logic [EXC_W-1:0] EXC_ADDR_STORE = 5'd5;

  typedef struct packed {
    route_t            route;
    logic              cached;
    logic [PA_W-1:0]   pa;
    logic [EXC_W-1:0]  exc;
    logic [EXT_W-1:0]  va;
  } seg_result_t;

  localparam int RESULT_W = $bits(seg_result_t);
endpackage

// File: rtl/seg_priv_eval.sv
module seg_priv_eval (
  input  logic [1:0] mode,
  input  logic       exl,
  input  logic       erl,
  output logic       kernel
);
  localparam logic [1:0] MODE_KERNEL = 2'b00;

  always_comb begin
    kernel = (mode == MODE_KERNEL) || exl || erl;
  end
endmodule

// File: rtl/seg_window.sv
module seg_window
  import seg_pkg::*;
(
  input  logic [VA_W-1:0] va,
  input  logic            kernel,
  input  logic            erl,
  input  logic            is_write,
  output seg_result_t     res
);
  localparam logic [2:0] WIN_CACHED   = 3'b100;
  localparam logic [2:0] WIN_UNCACHED = 3'b101;

  logic upper;
  assign upper = va[VA_W-1];

  always_comb begin
    res        = '0;
    res.route  = RT_TLB;
    res.exc    = EXC_NONE;
    res.va     = {{(EXT_W-VA_W){va[VA_W-1]}}, va};
    if (!upper) begin
      if (erl) begin
        res.route = RT_DIRECT;
        res.pa    = PA_W'(va[LOWWIN_BITS-1:0]);
      end
    end else if (kernel) begin
      case (va[VA_W-1:VA_W-3])
        WIN_CACHED: begin
          res.route  = RT_DIRECT;
          res.cached = 1'b1;
          res.pa     = PA_W'(va[KWIN_BITS-1:0]);
        end
        WIN_UNCACHED: begin
          res.route  = RT_DIRECT;
          res.pa     = PA_W'(va[KWIN_BITS-1:0]);
        end
        default: res.route = RT_TLB;
      endcase
    end else begin
      res.route = RT_ERR;
      res.exc   = is_write ? EXC_ADDR_STORE : EXC_ADDR_LOAD;
    end
  end
endmodule

// File: rtl/seg_hold_stage.sv
module seg_hold_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R9
  accept_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/addr_seg_decoder.sv
module addr_seg_decoder
  import seg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic [1:0]        req_mode,
  input  logic              req_exl,
  input  logic              req_erl,
  input  logic              req_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [2:0]        rsp_route,
  output logic              rsp_cached,
  output logic [PA_W-1:0]   rsp_pa,
  output logic [EXC_W-1:0]  rsp_exc,
  output logic [EXT_W-1:0]  rsp_va
);
  logic        kernel;
  seg_result_t next_res;
  seg_result_t held_res;
  logic [RESULT_W-1:0] held_bits;

  seg_priv_eval u_priv (
    .mode  (req_mode),
    .exl   (req_exl),
    .erl   (req_erl),
    .kernel(kernel)
  );

  seg_window u_win (
    .va      (req_va),
    .kernel  (kernel),
    .erl     (req_erl),
    .is_write(req_write),
    .res     (next_res)
  );

  seg_hold_stage #(.W(RESULT_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (req_valid),
    .in_ready (req_ready),
    .in_data  (next_res),
    .out_valid(rsp_valid),
    .out_ready(rsp_ready),
    .out_data (held_bits)
  );

  assign held_res   = seg_result_t'(held_bits);
  assign rsp_route  = held_res.route;
  assign rsp_cached = held_res.cached;
  assign rsp_pa     = held_res.pa;
  assign rsp_exc    = held_res.exc;
  assign rsp_va     = held_res.va;

  // R11
  route_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones(rsp_route) == 1));

  // R6
  err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_route[2]) |-> (rsp_exc == EXC_ADDR_LOAD || rsp_exc == EXC_ADDR_STORE));

  // R6
  no_err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_route[2]) |-> (rsp_exc == EXC_NONE));

  // R3
  cached_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cached) |-> (rsp_route == 3'b010 && rsp_pa[PA_W-1:KWIN_BITS] == '0
                                   && rsp_va[31:29] == 3'b100));

  // R8
  sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_va[EXT_W-1:VA_W] == {(EXT_W-VA_W){rsp_va[VA_W-1]}}));
endmodule

// File: tb/sim_addr_seg_decoder.sv
module sim_addr_seg_decoder;
  typedef struct packed {
    logic [2:0]  route;
    logic        cached;
    logic [31:0] pa;
    logic [4:0]  exc;
    logic [63:0] va;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [31:0] req_va = '0;
  logic [1:0]  req_mode = '0;
  logic req_exl = 1'b0, req_erl = 1'b0, req_write = 1'b0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [2:0]  rsp_route;
  logic        rsp_cached;
  logic [31:0] rsp_pa;
  logic [4:0]  rsp_exc;
  logic [63:0] rsp_va;

  int checks = 0;
  int fails  = 0;
  int sent   = 0;
  int got    = 0;
  bit force_ready = 1'b1;
  bit done = 1'b0;
  exp_t q[$];
  logic [31:0] lfsr = 32'hACE1_2468;

  always #4 clk = ~clk;

  addr_seg_decoder u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_mode(req_mode), .req_exl(req_exl),
    .req_erl(req_erl), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_route(rsp_route), .rsp_cached(rsp_cached), .rsp_pa(rsp_pa),
    .rsp_exc(rsp_exc), .rsp_va(rsp_va)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [31:0] va, input logic [1:0] mode,
                                 input logic exl, input logic erl, input logic wr);
    exp_t e;
    logic kern;
    e = '0;
    e.va = {{32{va[31]}}, va};
    kern = (mode == 2'b00) || exl || erl;           // R1
    if (!va[31]) begin
      if (erl) begin e.route = 3'b010; e.pa = {1'b0, va[30:0]}; end   // R7
      else e.route = 3'b001;                                          // R2
    end else if (kern) begin
      if (va[31:29] == 3'b100) begin e.route = 3'b010; e.cached = 1'b1; e.pa = {3'b000, va[28:0]}; end // R3
      else if (va[31:29] == 3'b101) begin e.route = 3'b010; e.pa = {3'b000, va[28:0]}; end           // R4
      else e.route = 3'b001;                                                                         // R5
    end else begin
      e.route = 3'b100;                                 // R6
      e.exc = wr ? 5'd5 : 5'd4;
    end
    return e;
  endfunction

  function automatic string req_tag(input exp_t e, input logic [1:0] mode,
                                    input logic exl, input logic erl);
    if (e.route == 3'b100) return "R6";
    if (erl && !e.va[31]) return "R7";
    if (!e.va[31]) return "R2";
    if (e.cached) return "R3";
    if (e.route == 3'b010) return "R4";
    if (mode != 2'b00 && !exl && !erl) return "R1";
    return "R5";
  endfunction

  task automatic send(input logic [31:0] va, input logic [1:0] mode,
                      input logic exl, input logic erl, input logic wr);
    @(negedge clk);
    req_va = va; req_mode = mode; req_exl = exl; req_erl = erl; req_write = wr;
    req_valid = 1'b1;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    q.push_back(model(va, mode, exl, erl, wr));
    sent++;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  // monitor / scoreboard
  bit   stalled = 1'b0;
  exp_t held;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stalled) begin
        chk(rsp_valid === 1'b1, "R9", "valid held in stall", {63'd0, rsp_valid}, 64'd1);
        chk({rsp_route, rsp_cached, rsp_pa, rsp_exc, rsp_va} === held, "R9", "payload held in stall",
            rsp_pa, held.pa);
      end
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      rsp_ready = force_ready ? 1'b1 : lfsr[3];
      stalled = rsp_valid && !rsp_ready;
      held = {rsp_route, rsp_cached, rsp_pa, rsp_exc, rsp_va};
      if (rsp_valid && rsp_ready) begin
        if (q.size() == 0) begin
          chk(1'b0, "R9", "unexpected result", {61'd0, rsp_route}, 64'd0);
        end else begin
          exp_t e;
          string t;
          e = q.pop_front();
          got++;
          t = req_tag(e, 2'b00, 1'b0, 1'b0);
          chk(rsp_route === e.route, (e.route == 3'b100) ? "R6" : "R11", "route",
              {61'd0, rsp_route}, {61'd0, e.route});
          chk(rsp_cached === e.cached, "R11", "cached", {63'd0, rsp_cached}, {63'd0, e.cached});
          chk(rsp_pa === e.pa, (e.route == 3'b010) ? (e.va[31] ? "R3" : "R7") : "R2", "pa",
              {32'd0, rsp_pa}, {32'd0, e.pa});
          chk(rsp_exc === e.exc, "R6", "exc", {59'd0, rsp_exc}, {59'd0, e.exc});
          chk(rsp_va === e.va, "R8", "sign-extended va", rsp_va, e.va);
          if (t.len() == 0) fails++;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", got, sent);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  logic [31:0] rs;
  initial begin
    // R10: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R10", "valid in reset", {63'd0, rsp_valid}, 64'd0);
    chk(req_ready === 1'b1, "R10", "ready in reset", {63'd0, req_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R10", "valid after reset", {63'd0, rsp_valid}, 64'd0);

    // R9: one-cycle latency with consumer ready
    send(32'h8000_1234, 2'b00, 1'b0, 1'b0, 1'b0);
    @(negedge clk); #1;
    chk(rsp_valid === 1'b1, "R9", "latency one cycle", {63'd0, rsp_valid}, 64'd1);

    // directed corners
    send(32'h0000_0000, 2'b10, 1'b0, 1'b0, 1'b0); // R2 user low
    send(32'h7FFF_FFFF, 2'b00, 1'b0, 1'b0, 1'b1); // R2 kernel low
    send(32'h8000_0000, 2'b00, 1'b0, 1'b0, 1'b0); // R3 bottom
    send(32'h9FFF_FFFF, 2'b10, 1'b1, 1'b0, 1'b0); // R3 + R1 exl forces kernel
    send(32'hA000_0000, 2'b01, 1'b0, 1'b1, 1'b1); // R4 + R1 erl forces kernel
    send(32'hBFFF_FFFF, 2'b00, 1'b0, 1'b0, 1'b0); // R4 top
    send(32'hC000_0000, 2'b00, 1'b0, 1'b0, 1'b0); // R5
    send(32'hFFFF_FFFF, 2'b00, 1'b0, 1'b0, 1'b1); // R5
    send(32'h8000_0000, 2'b10, 1'b0, 1'b0, 1'b0); // R6 load
    send(32'hA123_4567, 2'b01, 1'b0, 1'b0, 1'b1); // R6 store supervisor
    send(32'hFFFF_0000, 2'b11, 1'b0, 1'b0, 1'b0); // R1 reserved mode
    send(32'h7FFF_FFFF, 2'b10, 1'b0, 1'b1, 1'b0); // R7 top of low region
    send(32'h1234_5678, 2'b00, 1'b0, 1'b1, 1'b1); // R7

    // back-pressure sweep
    force_ready = 1'b0;
    rs = 32'h1357_9BDF;
    for (int i = 0; i < 600; i++) begin
      rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
      send({rs[2:0], rs[31:3]} ^ {3'b000, rs[28:0]} & 32'h1FFF_FFFF | {rs[2:0], 29'd0},
           rs[4:3], rs[5] & rs[6], rs[7] & rs[8] & rs[9], rs[10]);
    end
    force_ready = 1'b1;
    repeat (6) @(negedge clk);
    chk(got == sent, "R9", "all results delivered", got, sent);
    chk(q.size() == 0, "R9", "scoreboard empty", q.size(), 0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule